// File: doc/BRIEF.md
# Synthesizer Lock Monitor with Reference Divider

This block sits in the crystal-clock domain of a frequency synthesizer. It divides the crystal clock by a fixed ratio to form the reference comparison rate. It watches the up and down correction pulses of the charge pump and keeps a lock flag. The flag falls at once when a pump pulse stays high for longer than one crystal period. It rises again only after a fixed run of whole reference periods in which every pump pulse was narrow. The clear is fast and the set is slow, so the flag does not chatter while the loop settles.

The block also registers a pump-current select bit for the analog pump. It drives three general-purpose port outputs from software-written bits. When test mode is on, the lowest port carries the reference signal and the middle port carries the divided input signal, so both can be probed at the pins.

Top module: `pll_lock_monitor`

## Requirements
- R1: While reset is held (active-low, synchronous), lock_flag, pump_cur_sel and every bit of port_out are 0.
- R2: The reference signal repeats every DIV_RATIO (default 64) crystal cycles. It is low for the first half of the period and high for the second half, and it is seen on port_out[0] in test mode.
- R3: After reset, lock_flag becomes 1 at the end of the LOCK_RUN-th (default 8) clean reference period, and not before.
- R4: A pump pulse that stays high for more than MAX_WIDTH (default 1) consecutive crystal cycles clears lock_flag within 4 crystal cycles of the pulse's leading edge at the input.
- R5: Pump pulses of one crystal cycle on either pump_up or pump_dn, with gaps between them, leave lock_flag at 1.
- R6: Width is judged on the OR of pump_up and pump_dn. A one-cycle up pulse followed at once by a one-cycle down pulse counts as too wide.
- R7: After a too-wide pulse, lock_flag stays 0 for at least LOCK_RUN reference periods. It returns to 1 within LOCK_RUN+1 periods when no further violation occurs.
- R8: pump_cur_sel equals cur_sel_bit as it was one crystal cycle earlier.
- R9: With test_en at 0, port_out equals port_bits as it was one cycle earlier, and div_in has no effect.
- R10: With test_en at 1, port_out[1] carries div_in delayed one cycle, port_out[2] still follows port_bits[2], and port_out[0] carries the reference signal.
- R11: A too-wide pulse while the flag is being reacquired restarts the clean-period count from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pump_up | input | 1 | Charge-pump up pulse, asynchronous |
| pump_dn | input | 1 | Charge-pump down pulse, asynchronous |
| div_in | input | 1 | Divided input signal, routed out in test mode |
| cur_sel_bit | input | 1 | Software pump-current choice |
| test_en | input | 1 | Test routing enable |
| port_bits | input | 3 | Software values for the low, mid and high ports |
| lock_flag | output | 1 | Lock indication |
| pump_cur_sel | output | 1 | Registered pump-current select |
| port_out | output | 3 | Port outputs: bit 0 low, bit 1 mid, bit 2 high |

## Verification
A wrong clean-period count shows up only as a lock flag that rises too early or too late. So the bench aligns to the reference edge on port_out[0] and checks the flag on both sides of the eight-to-nine period window. Missing sticky violation state, or a count that is not cleared, makes the flag rise several periods early; a second violation placed during reacquisition shows this within about five periods. A wrong width comparison shows within four cycles as a flag that falls on a narrow pulse or survives a wide one.

// File: rtl/plm_pkg.sv
// Shared defaults and types for the synthesizer lock monitor.
// Assumes all logic runs on the crystal clock.
package plm_pkg;
    localparam int unsigned DEF_DIV_RATIO = 64;
    localparam int unsigned DEF_LOCK_RUN  = 8;
    localparam int unsigned DEF_MAX_WIDTH = 1;
    localparam int unsigned DEF_SYNC      = 2;
    localparam int unsigned DEF_NPORT     = 3;

    // Index of each port bit; routing in test mode depends on these.
    localparam int unsigned PORT_LOW  = 0;
    localparam int unsigned PORT_MID  = 1;
endpackage

// File: rtl/plm_ref_divider.sv
// Reference divider: counts crystal cycles modulo DIV_RATIO.
// Emits a one-cycle strobe in the last cycle of each period and a
// square reference signal, low for the first half and high for the second.
// Assumes DIV_RATIO >= 4.
module plm_ref_divider #(
    parameter int unsigned DIV_RATIO = plm_pkg::DEF_DIV_RATIO
) (
    input  logic clk,
    input  logic rst_n,
    output logic strobe_o,
    output logic ref_o
);
    localparam int unsigned CW   = $clog2(DIV_RATIO);
    localparam int unsigned LAST = DIV_RATIO - 1;
    localparam int unsigned HALF = DIV_RATIO / 2;

    logic [CW-1:0] cnt_q;

    // Period counter, wraps at DIV_RATIO-1.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (cnt_q == CW'(LAST)) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Strobe and reference level decoded from the count.
    always_comb begin
        strobe_o = (cnt_q == CW'(LAST));
        ref_o    = (cnt_q >= CW'(HALF));
    end

    p_count_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(LAST));
    p_strobe_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_o |=> (!strobe_o && cnt_q == '0));
endmodule

// File: rtl/plm_width_check.sv
// Pulse-width checker: synchronizes the up and down pump pulses, ORs
// them and counts consecutive high crystal cycles. Flags a violation in
// every cycle where the OR has been high longer than MAX_WIDTH cycles.
// Assumes pump inputs are asynchronous to clk.
module plm_width_check #(
    parameter int unsigned SYNC_STAGES = plm_pkg::DEF_SYNC,
    parameter int unsigned MAX_WIDTH   = plm_pkg::DEF_MAX_WIDTH
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pump_up,
    input  logic pump_dn,
    output logic viol_o
);
    localparam int unsigned RW = $clog2(MAX_WIDTH + 1) + 1;

    logic [SYNC_STAGES-1:0] up_sync_q;
    logic [SYNC_STAGES-1:0] dn_sync_q;
    logic                   pulse;
    logic [RW-1:0]          run_q;

    // First synchronizer stage samples the raw pump lines.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            up_sync_q[0] <= 1'b0;
            dn_sync_q[0] <= 1'b0;
        end else begin
            up_sync_q[0] <= pump_up;
            dn_sync_q[0] <= pump_dn;
        end
    end

    // Remaining synchronizer stages.
    for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_sync
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                up_sync_q[s] <= 1'b0;
                dn_sync_q[s] <= 1'b0;
            end else begin
                up_sync_q[s] <= up_sync_q[s-1];
                dn_sync_q[s] <= dn_sync_q[s-1];
            end
        end
    end

    assign pulse = up_sync_q[SYNC_STAGES-1] | dn_sync_q[SYNC_STAGES-1];

    // Run length of the combined pulse, saturating at MAX_WIDTH.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (!pulse) begin
            run_q <= '0;
        end else if (run_q < RW'(MAX_WIDTH)) begin
            run_q <= run_q + 1'b1;
        end
    end

    // Too wide: still high after MAX_WIDTH high cycles.
    always_comb viol_o = pulse && (run_q >= RW'(MAX_WIDTH));

    p_run_saturates_r4: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= RW'(MAX_WIDTH));
    p_viol_needs_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        viol_o |-> $past(up_sync_q[SYNC_STAGES-1] | dn_sync_q[SYNC_STAGES-1]));
endmodule

// File: rtl/plm_lock_track.sv
// Lock tracker: keeps a sticky per-period violation bit and a
// saturating count of clean reference periods. Clears the flag on any
// violation; sets it when the count reaches LOCK_RUN at a period strobe.
// Assumes strobe_i is one cycle wide and periodic.
module plm_lock_track #(
    parameter int unsigned LOCK_RUN = plm_pkg::DEF_LOCK_RUN
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_i,
    input  logic viol_i,
    output logic lock_o
);
    localparam int unsigned NW = $clog2(LOCK_RUN + 1);

    logic [NW-1:0] clean_q;
    logic          bad_q;
    logic          lock_q;
    logic          period_bad;

    assign period_bad = bad_q | viol_i;

    // Clean-period counter and per-period violation memory.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clean_q <= '0;
            bad_q   <= 1'b0;
        end else if (strobe_i) begin
            bad_q <= 1'b0;
            if (period_bad) begin
                clean_q <= '0;
            end else if (clean_q < NW'(LOCK_RUN)) begin
                clean_q <= clean_q + 1'b1;
            end
        end else if (viol_i) begin
            bad_q   <= 1'b1;
            clean_q <= '0;
        end
    end

    // Lock flag: fast clear, slow set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_q <= 1'b0;
        end else if (viol_i) begin
            lock_q <= 1'b0;
        end else if (strobe_i && !bad_q && clean_q == NW'(LOCK_RUN - 1)) begin
            lock_q <= 1'b1;
        end
    end

    assign lock_o = lock_q;

    p_clear_on_wide_r4: assert property (@(posedge clk) disable iff (!rst_n)
        viol_i |=> !lock_o);
    p_set_on_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_o) |-> $past(strobe_i));
    p_count_capped_r11: assert property (@(posedge clk) disable iff (!rst_n)
        clean_q <= NW'(LOCK_RUN));
    p_wide_restarts_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (viol_i && !strobe_i) |=> (clean_q == '0 && bad_q));
endmodule

// File: rtl/plm_port_ctl.sv
// Port and current-select register stage. Outside test mode every port
// follows its software bit; in test mode the low port carries the
// reference and the mid port the divided input. All outputs are registered.
// Assumes NPORT >= 2.
module plm_port_ctl #(
    parameter int unsigned NPORT = plm_pkg::DEF_NPORT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cur_sel_i,
    input  logic             test_i,
    input  logic             ref_i,
    input  logic             div_i,
    input  logic [NPORT-1:0] bits_i,
    output logic             cur_sel_o,
    output logic [NPORT-1:0] port_o
);
    logic [NPORT-1:0] port_d;

    // Test routing for the two probe ports; the rest pass through.
    always_comb begin
        port_d = bits_i;
        if (test_i) begin
            port_d[plm_pkg::PORT_LOW] = ref_i;
            port_d[plm_pkg::PORT_MID] = div_i;
        end
    end

    // Output registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_sel_o <= 1'b0;
            port_o    <= '0;
        end else begin
            cur_sel_o <= cur_sel_i;
            port_o    <= port_d;
        end
    end

    p_cur_sel_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> cur_sel_o == $past(cur_sel_i));
    p_plain_ports_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(test_i)) |-> port_o == $past(bits_i));
    p_test_mid_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(test_i)) |-> port_o[plm_pkg::PORT_MID] == $past(div_i));
endmodule

// File: rtl/pll_lock_monitor.sv
// Top of the synthesizer lock monitor. Wires the reference divider, the
// pump pulse-width checker, the lock tracker and the port register stage.
// Assumes clk is the crystal clock and reset is synchronous, active low.
module pll_lock_monitor #(
    parameter int unsigned DIV_RATIO   = plm_pkg::DEF_DIV_RATIO,
    parameter int unsigned LOCK_RUN    = plm_pkg::DEF_LOCK_RUN,
    parameter int unsigned MAX_WIDTH   = plm_pkg::DEF_MAX_WIDTH,
    parameter int unsigned SYNC_STAGES = plm_pkg::DEF_SYNC,
    parameter int unsigned NPORT       = plm_pkg::DEF_NPORT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pump_up,
    input  logic             pump_dn,
    input  logic             div_in,
    input  logic             cur_sel_bit,
    input  logic             test_en,
    input  logic [NPORT-1:0] port_bits,
    output logic             lock_flag,
    output logic             pump_cur_sel,
    output logic [NPORT-1:0] port_out
);
    logic ref_strobe;
    logic ref_level;
    logic wide_viol;

    plm_ref_divider #(.DIV_RATIO(DIV_RATIO)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe_o (ref_strobe),
        .ref_o    (ref_level)
    );

    plm_width_check #(.SYNC_STAGES(SYNC_STAGES), .MAX_WIDTH(MAX_WIDTH)) u_width (
        .clk     (clk),
        .rst_n   (rst_n),
        .pump_up (pump_up),
        .pump_dn (pump_dn),
        .viol_o  (wide_viol)
    );

    plm_lock_track #(.LOCK_RUN(LOCK_RUN)) u_lock (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe_i (ref_strobe),
        .viol_i   (wide_viol),
        .lock_o   (lock_flag)
    );

    plm_port_ctl #(.NPORT(NPORT)) u_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .cur_sel_i (cur_sel_bit),
        .test_i    (test_en),
        .ref_i     (ref_level),
        .div_i     (div_in),
        .bits_i    (port_bits),
        .cur_sel_o (pump_cur_sel),
        .port_o    (port_out)
    );

    p_reset_quiet_r1: assert property (@(posedge clk)
        !$past(rst_n) |-> (!lock_flag && !pump_cur_sel && port_out == '0));
endmodule

// File: tb/pll_lock_monitor_tb.sv
// Scoreboard bench: the driver pushes expected items, the monitor pops
// and compares them half a cycle after the driving edge.
module pll_lock_monitor_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int PER        = 64;
    localparam int RUN        = 8;
    localparam int WATCHDOG   = 150000;

    typedef struct {
        string      req;
        int         sel;   // 0 lock_flag, 1 pump_cur_sel, 2 port_out
        logic [2:0] exp;
        logic [2:0] mask;
    } item_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pump_up = 1'b0, pump_dn = 1'b0, div_in = 1'b0;
    logic       cur_sel_bit = 1'b0, test_en = 1'b0;
    logic [2:0] port_bits = '0;
    logic       lock_flag, pump_cur_sel;
    logic [2:0] port_out;

    int    n_tests = 0;
    int    n_fail  = 0;
    int    cyc     = 0;
    item_t sb_q[$];

    pll_lock_monitor dut_i (
        .clk(clk), .rst_n(rst_n), .pump_up(pump_up), .pump_dn(pump_dn),
        .div_in(div_in), .cur_sel_bit(cur_sel_bit), .test_en(test_en),
        .port_bits(port_bits), .lock_flag(lock_flag),
        .pump_cur_sel(pump_cur_sel), .port_out(port_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic void check_val(string req, logic [2:0] got, logic [2:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", req, got, exp);
        end
    endfunction

    task automatic expect_item(string req, int sel, logic [2:0] exp, logic [2:0] mask);
        item_t it;
        it.req = req; it.sel = sel; it.exp = exp; it.mask = mask;
        sb_q.push_back(it);
    endtask

    // Monitor: compares queued expectations away from the clock edge.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (sb_q.size() > 0) begin
                item_t it;
                logic [2:0] obs;
                it  = sb_q.pop_front();
                obs = (it.sel == 0) ? {2'b00, lock_flag} :
                      (it.sel == 1) ? {2'b00, pump_cur_sel} : port_out;
                check_val(it.req, obs & it.mask, it.exp & it.mask);
            end
        end
    end

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_until(int c);
        while (cyc < c) @(negedge clk);
    endtask

    // Align to the falling reference edge seen on the low port (test mode).
    task automatic align_ref(output int at);
        @(negedge port_out[0]);
        @(negedge clk);
        at = cyc;
    endtask

    task automatic wide_pulse();
        pump_up = 1'b1;
        wait_cyc(2);
        pump_up = 1'b0;
    endtask

    task automatic run_tests();
        int a, a2, rel, lo_len, hi_len;
        wait_cyc(4);
        expect_item("R1", 0, 3'b000, 3'b001);
        expect_item("R1", 1, 3'b000, 3'b001);
        expect_item("R1", 2, 3'b000, 3'b111);
        wait_cyc(1);
        rst_n = 1'b1;
        rel = cyc;

        // R8: current select delayed one cycle.
        cur_sel_bit = 1'b1;
        wait_cyc(1);
        expect_item("R8", 1, 3'b001, 3'b001);
        cur_sel_bit = 1'b0;
        wait_cyc(1);
        expect_item("R8", 1, 3'b000, 3'b001);

        // R9: ports follow software bits; div_in ignored.
        port_bits = 3'b101;
        div_in = 1'b1;
        wait_cyc(1);
        expect_item("R9", 2, 3'b101, 3'b111);
        port_bits = 3'b010;
        div_in = 1'b0;
        wait_cyc(1);
        expect_item("R9", 2, 3'b010, 3'b111);

        // R3: flag rises only after the eighth clean period.
        wait_until(rel + RUN*PER - 12);
        expect_item("R3", 0, 3'b000, 3'b001);
        wait_until(rel + RUN*PER + 12);
        expect_item("R3", 0, 3'b001, 3'b001);

        // R10: test routing.
        test_en = 1'b1;
        port_bits = 3'b100;
        div_in = 1'b1;
        wait_cyc(1);
        expect_item("R10", 2, 3'b110, 3'b110);
        div_in = 1'b0;
        port_bits = 3'b000;
        wait_cyc(1);
        expect_item("R10", 2, 3'b000, 3'b110);

        // R2: reference shape on the low port.
        align_ref(a);
        lo_len = 0;
        while (port_out[0] == 1'b0) begin lo_len++; @(negedge clk); end
        hi_len = 0;
        while (port_out[0] == 1'b1) begin hi_len++; @(negedge clk); end
        check_val("R2", lo_len[2:0] ^ 3'(lo_len != PER/2), 3'(PER/2 % 8));
        n_tests++;
        if (lo_len != PER/2 || hi_len != PER/2) begin
            n_fail++;
            $display("FAIL R2: low %0d high %0d expected %0d each", lo_len, hi_len, PER/2);
        end

        // R5: isolated one-cycle pulses on either line keep the flag.
        for (int i = 0; i < 24; i++) begin
            if (i % 2 == 0) pump_up = 1'b1; else pump_dn = 1'b1;
            wait_cyc(1);
            pump_up = 1'b0;
            pump_dn = 1'b0;
            wait_cyc(7);
        end
        wait_cyc(4);
        expect_item("R5", 0, 3'b001, 3'b001);

        // R4 and R7: wide pulse clears fast, reacquire takes 8..9 periods.
        align_ref(a);
        wide_pulse();
        wait_cyc(2);
        expect_item("R4", 0, 3'b000, 3'b001);
        wait_until(a + RUN*PER + 28);
        expect_item("R7", 0, 3'b000, 3'b001);
        wait_until(a + (RUN+1)*PER + 24);
        expect_item("R7", 0, 3'b001, 3'b001);

        // R11: second violation during reacquisition restarts the count.
        align_ref(a);
        wide_pulse();
        wait_until(a + 5*PER - 20);
        align_ref(a2);
        wide_pulse();
        wait_until(a2 + 300);
        expect_item("R11", 0, 3'b000, 3'b001);
        wait_until(a2 + RUN*PER + 28);
        expect_item("R11", 0, 3'b000, 3'b001);
        wait_until(a2 + (RUN+1)*PER + 24);
        expect_item("R11", 0, 3'b001, 3'b001);

        // R6: adjacent up and down one-cycle pulses count as one wide pulse.
        align_ref(a);
        pump_up = 1'b1;
        wait_cyc(1);
        pump_up = 1'b0;
        pump_dn = 1'b1;
        wait_cyc(1);
        pump_dn = 1'b0;
        wait_cyc(3);
        expect_item("R6", 0, 3'b000, 3'b001);
        wait_cyc(3);
    endtask

    initial begin
        fork
            run_tests();
            begin
                wait (cyc >= WATCHDOG);
                n_tests++;
                n_fail++;
                $display("FAIL watchdog: got %0d cycles expected fewer than %0d", cyc, WATCHDOG);
            end
        join_any
        disable fork;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule